// File: doc/BRIEF.md
# Synchronous Burst SRAM

This block is a small synchronous static memory with a built-in two-bit burst address counter. Address, write data, chip enable, both address strobes, the advance input and the write controls are all captured on the rising clock edge. Either strobe starts a burst at the presented address. After that, the low two address bits step through a four-beat sequence on each cycle where the advance input is high. The upper address bits do not change. One mode input picks linear or interleaved beat order. A second mode input places read data on the output in the same cycle as the command (flow-through) or one edge later through an output register (pipelined).

Writes go either per byte, using a byte-write enable together with byte selects, or to the whole word through a global write that ignores the byte controls. A strobe with the chip enable low ends the burst. This deselect travels down the read pipeline, so the outputs keep driving through one more edge before they release. The output enable and the sleep input gate the output drive asynchronously. While sleep is high, every command is ignored and the stored data is kept. The tri-state data bus is modelled as a data output plus a drive flag. While the drive flag is low, the data output reads as zero.

Top module: `sync_burst_sram`

## Requirements
- R1: After reset, `dq_drive` is 0 and `dq_out` is all zeros until a read is issued.
- R2: An access starts when `start_a` or `start_b` is high with `chip_en` high. The two strobes behave identically, and the word at `addr` is the first beat.
- R3: With `burst_lin`=0 (interleaved), beat n (n=0..3) addresses `{start[AW-1:2], start[1:0] XOR n}`.
- R4: With `burst_lin`=1 (linear), beat n addresses `{start[AW-1:2], (start[1:0]+n) mod 4}`.
- R5: The beat index advances only in cycles where `adv` is high and no strobe is present. A cycle with neither a strobe nor `adv` repeats the current address.
- R6: With `pipe_mode`=0 (flow-through), read data and `dq_drive`=1 appear right after the edge that samples the read.
- R7: With `pipe_mode`=1 (pipelined), read data and `dq_drive`=1 appear right after the edge that follows the read edge.
- R8: With `wr_all`=0 and `wr_byte_en`=1, only the bytes whose `byte_sel` bit b is 1 are written (bit b covers `din[8b+7:8b]`). With `wr_byte_en`=0 and `wr_all`=0, the access is a read and nothing is written.
- R9: With `wr_all`=1, every byte is written, whatever `wr_byte_en` and `byte_sel` are.
- R10: A strobe with `chip_en`=0 is a deselect. After a read, the output stays driven with the last read word until the edge after the deselect edge, then releases. Two deselects in a row leave the output released.
- R11: When `oe` is 0, `dq_drive` is 0 at once. When `oe` returns to 1, the pending read data reappears, because the read pipeline is not disturbed.
- R12: When `sleep` is 1, `dq_drive` is 0 at once, commands are ignored, and the stored data and pipeline state are kept.
- R13: A strobe in the middle of a burst aborts it and restarts the beat counter at the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chip_en | input | 1 | Chip select sampled with a strobe; 0 with a strobe is a deselect |
| start_a | input | 1 | Address strobe A |
| start_b | input | 1 | Address strobe B |
| adv | input | 1 | Burst advance |
| addr | input | ADDR_W | Start address |
| burst_lin | input | 1 | 1 linear order, 0 interleaved order |
| pipe_mode | input | 1 | 1 registered read data, 0 flow-through |
| wr_byte_en | input | 1 | Byte-write enable |
| byte_sel | input | DATA_W/8 | Per-byte write selects |
| wr_all | input | 1 | Global write of all bytes |
| din | input | DATA_W | Write data |
| oe | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Asynchronous sleep; ignores commands, releases outputs |
| dq_drive | output | 1 | High while the data bus is driven |
| dq_out | output | DATA_W | Read data, zero while not driven |

## Verification
In flow-through mode, read data is due in the cycle right after the command edge. In pipelined mode it is due one edge later. After a deselect, the release is due two edges after the last read in both modes. The output enable and sleep act within the same cycle, with no edge involved. The bench changes inputs on the falling edge and samples two nanoseconds after each rising edge, so every check reads the state that the most recent edge produced. For each beat it compares the output with a reference memory, using addresses it computes itself for the selected order and mode.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  typedef enum logic {
    ORD_INTERLEAVE = 1'b0,
    ORD_LINEAR     = 1'b1
  } burst_ord_e;

  // Low two address bits of a beat, given the start bits and beat index.
  function automatic logic [1:0] beat_lsb(input logic [1:0] start,
                                          input logic [1:0] idx,
                                          input burst_ord_e ord);
    return (ord == ORD_LINEAR) ? (start + idx) : (start ^ idx);
  endfunction
endpackage

// File: rtl/sbs_burst_ctr.sv
module sbs_burst_ctr
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              load,
  input  logic              ce,
  input  logic              adv,
  input  burst_ord_e        ord,
  input  logic [ADDR_W-1:0] addr,
  output logic              acc,
  output logic              desel,
  output logic [ADDR_W-1:0] acc_addr
);
  logic [ADDR_W-1:0] base_q, base_d;
  logic [1:0]        idx_q, idx_d;
  logic              act_q, act_d;

  always_comb begin
    base_d = base_q;
    idx_d  = idx_q;
    act_d  = act_q;
    if (load) begin
      base_d = addr;
      idx_d  = 2'd0;
      act_d  = ce;
    end else if (adv && act_q) begin
      idx_d = idx_q + 2'd1;
    end
  end

  assign acc      = run && (load ? ce : act_q);
  assign desel    = run && load && !ce;
  assign acc_addr = {base_d[ADDR_W-1:2], beat_lsb(base_d[1:0], idx_d, ord)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      idx_q  <= 2'd0;
      act_q  <= 1'b0;
    end else if (run) begin
      base_q <= base_d;
      idx_q  <= idx_d;
      act_q  <= act_d;
    end
  end
endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic [DATA_W/8-1:0] we,
  input  logic [ADDR_W-1:0]   waddr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [ADDR_W-1:0]   raddr,
  output logic [DATA_W-1:0]   rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int NB    = DATA_W / 8;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [7:0] lane [DEPTH];
    always_ff @(posedge clk) begin
      if (we[b]) lane[waddr] <= wdata[b*8 +: 8];
    end
    assign rdata[b*8 +: 8] = lane[raddr];
  end
endmodule

// File: rtl/sbs_rd_path.sv
module sbs_rd_path #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              acc,
  input  logic              rd,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              pipe,
  input  logic              oe,
  input  logic              sleep,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] raddr,
  output logic              dq_drive,
  output logic [DATA_W-1:0] dq_out
);
  logic              s1_acc_q, s1_acc_d;
  logic              s1_rd_q, s1_rd_d;
  logic [ADDR_W-1:0] s1_addr_q, s1_addr_d;
  logic              s2_rd_q, s2_rd_d;
  logic [DATA_W-1:0] s2_data_q, s2_data_d;
  logic              drive_int;
  logic [DATA_W-1:0] data_sel;

  always_comb begin
    s1_acc_d  = acc;
    s1_rd_d   = rd;
    s1_addr_d = acc ? acc_addr : s1_addr_q;
    s2_rd_d   = s1_rd_q;
    s2_data_d = s1_rd_q ? rdata : s2_data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_acc_q  <= 1'b0;
      s1_rd_q   <= 1'b0;
      s1_addr_q <= '0;
      s2_rd_q   <= 1'b0;
      s2_data_q <= '0;
    end else if (run) begin
      s1_acc_q  <= s1_acc_d;
      s1_rd_q   <= s1_rd_d;
      s1_addr_q <= s1_addr_d;
      s2_rd_q   <= s2_rd_d;
      s2_data_q <= s2_data_d;
    end
  end

  // Flow-through holds the drive one extra cycle after a deselect so that
  // both modes release at the same edge.
  assign drive_int = pipe ? s2_rd_q : (s1_rd_q || (s2_rd_q && !s1_acc_q));
  assign data_sel  = pipe ? s2_data_q : rdata;
  assign raddr     = s1_addr_q;
  assign dq_drive  = drive_int && oe && !sleep;
  assign dq_out    = dq_drive ? data_sel : '0;
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                chip_en,
  input  logic                start_a,
  input  logic                start_b,
  input  logic                adv,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                burst_lin,
  input  logic                pipe_mode,
  input  logic                wr_byte_en,
  input  logic [DATA_W/8-1:0] byte_sel,
  input  logic                wr_all,
  input  logic [DATA_W-1:0]   din,
  input  logic                oe,
  input  logic                sleep,
  output logic                dq_drive,
  output logic [DATA_W-1:0]   dq_out
);
  localparam int NB = DATA_W / 8;

  logic [1:0]        rst_sync_q;
  logic              rst_n_s;
  logic              run;
  logic              acc;
  logic              cmd_desel;
  logic              cmd_rd;
  logic [ADDR_W-1:0] acc_addr;
  logic [NB-1:0]     wmask;
  logic [NB-1:0]     we;
  logic [ADDR_W-1:0] raddr;
  logic [DATA_W-1:0] rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  assign run   = !sleep;
  assign wmask = wr_all ? {NB{1'b1}} : (wr_byte_en ? byte_sel : '0);
  assign we    = acc ? wmask : '0;
  assign cmd_rd = acc && (wmask == '0);

  sbs_burst_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .run      (run),
    .load     (start_a || start_b),
    .ce       (chip_en),
    .adv      (adv),
    .ord      (burst_ord_e'(burst_lin)),
    .addr     (addr),
    .acc      (acc),
    .desel    (cmd_desel),
    .acc_addr (acc_addr)
  );

  sbs_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk   (clk),
    .we    (we),
    .waddr (acc_addr),
    .wdata (din),
    .raddr (raddr),
    .rdata (rdata)
  );

  sbs_rd_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .run      (run),
    .acc      (acc),
    .rd       (cmd_rd),
    .acc_addr (acc_addr),
    .pipe     (pipe_mode),
    .oe       (oe),
    .sleep    (sleep),
    .rdata    (rdata),
    .raddr    (raddr),
    .dq_drive (dq_drive),
    .dq_out   (dq_out)
  );
endmodule

// File: rtl/sbs_chk.sv
module sbs_chk (
  input logic clk,
  input logic rst_n,
  input logic pipe_mode,
  input logic oe,
  input logic sleep,
  input logic cmd_rd,
  input logic cmd_desel,
  input logic dq_drive
);
  logic [1:0] warm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             warm_q <= 2'd0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  a_r12_sleep_tristate: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !dq_drive);

  a_r11_oe_tristate: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> !dq_drive);

  a_r6_flow_read_on: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q >= 2'd1 && !pipe_mode && oe && !sleep && $past(cmd_rd)) |-> dq_drive);

  a_r7_pipe_read_on: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q >= 2'd2 && pipe_mode && oe && !sleep && !$past(sleep) && $past(cmd_rd, 2))
      |-> dq_drive);

  a_r10_dcd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q >= 2'd2 && oe && !sleep && !$past(sleep) && $past(cmd_desel) && $past(cmd_rd, 2))
      |-> dq_drive);

  a_r10_dcd_off: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q >= 2'd2 && $past(cmd_desel) && $past(cmd_desel, 2)) |-> !dq_drive);
endmodule

bind sync_burst_sram sbs_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .pipe_mode (pipe_mode),
  .oe        (oe),
  .sleep     (sleep),
  .cmd_rd    (cmd_rd),
  .cmd_desel (cmd_desel),
  .dq_drive  (dq_drive)
);

// File: tb/sim_sync_burst_sram.sv
`timescale 1ns/1ps
module sim_sync_burst_sram;
  localparam int AW    = 6;
  localparam int DW    = 32;
  localparam int NB    = DW / 8;
  localparam int DEPTH = 1 << AW;

  // {start[5:0], linear, pipelined, use strobe B}
  localparam logic [8:0] BURSTS [8] = '{
    {6'd0,  1'b0, 1'b0, 1'b0},
    {6'd6,  1'b0, 1'b0, 1'b1},
    {6'd17, 1'b1, 1'b0, 1'b0},
    {6'd23, 1'b1, 1'b0, 1'b1},
    {6'd33, 1'b0, 1'b1, 1'b0},
    {6'd46, 1'b0, 1'b1, 1'b1},
    {6'd50, 1'b1, 1'b1, 1'b1},
    {6'd63, 1'b1, 1'b1, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chip_en = 1'b0, start_a = 1'b0, start_b = 1'b0, adv = 1'b0;
  logic [AW-1:0] addr = '0;
  logic burst_lin = 1'b0, pipe_mode = 1'b0;
  logic wr_byte_en = 1'b0, wr_all = 1'b0;
  logic [NB-1:0] byte_sel = '0;
  logic [DW-1:0] din = '0;
  logic oe = 1'b1, sleep = 1'b0;
  logic dq_drive;
  logic [DW-1:0] dq_out;

  logic [DW-1:0] ref_mem [DEPTH];
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sync_burst_sram #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .start_a(start_a), .start_b(start_b),
    .adv(adv), .addr(addr), .burst_lin(burst_lin), .pipe_mode(pipe_mode),
    .wr_byte_en(wr_byte_en), .byte_sel(byte_sel), .wr_all(wr_all), .din(din),
    .oe(oe), .sleep(sleep), .dq_drive(dq_drive), .dq_out(dq_out)
  );

  function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] s, input int n,
                                              input logic lin);
    logic [1:0] lo;
    lo = lin ? (s[1:0] + 2'(n)) : (s[1:0] ^ 2'(n));
    return {s[AW-1:2], lo};
  endfunction

  task automatic chk_out(input string req, input logic exp_drv, input logic [DW-1:0] exp_dat);
    logic [DW:0] act, exp;
    act = {dq_drive, dq_out};
    exp = {exp_drv, exp_drv ? exp_dat : {DW{1'b0}}};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic sa, input logic sb, input logic ce, input logic ad,
                      input logic [AW-1:0] a, input logic bwe, input logic [NB-1:0] bs,
                      input logic wa, input logic [DW-1:0] d);
    @(negedge clk);
    start_a = sa; start_b = sb; chip_en = ce; adv = ad; addr = a;
    wr_byte_en = bwe; byte_sel = bs; wr_all = wa; din = d;
    @(posedge clk);
    #2;
  endtask

  task automatic idle();        step(0, 0, 0, 0, '0, 0, '0, 0, '0); endtask
  task automatic desel();       step(1, 0, 0, 0, '0, 0, '0, 0, '0); endtask
  task automatic advance();     step(0, 0, 0, 1, '0, 0, '0, 0, '0); endtask
  task automatic hold();        step(0, 0, 0, 0, '0, 0, '0, 0, '0); endtask
  task automatic rd(input logic [AW-1:0] a, input logic useb);
    step(!useb, useb, 1, 0, a, 0, '0, 0, '0);
  endtask
  task automatic wr_word(input logic [AW-1:0] a, input logic [DW-1:0] d);
    step(1, 0, 1, 0, a, 0, '0, 1, d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] s;
    logic lin, pm, ub;
    string oreq;

    // R1: reset state
    repeat (3) @(posedge clk);
    #2 chk_out("R1 in reset", 1'b0, '0);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2 chk_out("R1 after release", 1'b0, '0);

    // Fill the memory with global writes.
    for (int i = 0; i < DEPTH; i++) begin
      logic [DW-1:0] v;
      v = 32'h5A00_0000 ^ (32'(i) * 32'h0103_0507);
      wr_word(AW'(i), v);
      ref_mem[i] = v;
    end
    desel();
    idle();

    // Table of bursts: order, read mode and strobe choice.
    for (int e = 0; e < 8; e++) begin
      {s, lin, pm, ub} = BURSTS[e];
      burst_lin = lin;
      pipe_mode = pm;
      oreq = lin ? "R4" : "R3";
      rd(s, ub);
      if (!pm) chk_out({"R2 R6 ", oreq, " beat0"}, 1'b1, ref_mem[beat_addr(s, 0, lin)]);
      for (int j = 1; j < 4; j++) begin
        advance();
        if (!pm) chk_out({"R6 ", oreq, " beat"}, 1'b1, ref_mem[beat_addr(s, j, lin)]);
        else     chk_out({"R7 ", oreq, " beat"}, 1'b1, ref_mem[beat_addr(s, j - 1, lin)]);
      end
      desel();
      chk_out("R10 hold after deselect", 1'b1, ref_mem[beat_addr(s, 3, lin)]);
      idle();
      chk_out("R10 released", 1'b0, '0);
    end

    // R8: byte write, selects 0 and 2 only.
    pipe_mode = 1'b0;
    burst_lin = 1'b1;
    step(1, 0, 1, 0, 6'd5, 1, 4'b0101, 0, 32'h1122_3344);
    ref_mem[5][7:0]   = 8'h44;
    ref_mem[5][23:16] = 8'h22;
    desel();
    rd(6'd5, 0);
    chk_out("R8 byte write lanes", 1'b1, ref_mem[5]);
    // R8: selects without the byte-write enable make a read.
    step(1, 0, 1, 0, 6'd6, 0, 4'b1111, 0, 32'hFFFF_FFFF);
    chk_out("R8 no enable is read", 1'b1, ref_mem[6]);
    desel();
    rd(6'd6, 1);
    chk_out("R8 word unchanged", 1'b1, ref_mem[6]);

    // R9: global write overrides the byte controls.
    step(1, 0, 1, 0, 6'd7, 0, 4'b0000, 1, 32'hCAFE_F00D);
    ref_mem[7] = 32'hCAFE_F00D;
    step(0, 1, 1, 0, 6'd8, 1, 4'b0001, 1, 32'h0BAD_BEEF);
    ref_mem[8] = 32'h0BAD_BEEF;
    desel();
    rd(6'd7, 0);
    chk_out("R9 global no selects", 1'b1, ref_mem[7]);
    rd(6'd8, 0);
    chk_out("R9 global over selects", 1'b1, ref_mem[8]);

    // R5 and R13: advance gating and restart mid-burst (linear, flow).
    rd(6'd9, 0);
    chk_out("R5 start", 1'b1, ref_mem[9]);
    hold();
    chk_out("R5 no advance repeats", 1'b1, ref_mem[9]);
    advance();
    chk_out("R5 advance steps", 1'b1, ref_mem[10]);
    rd(6'd40, 1);
    chk_out("R13 restart at new address", 1'b1, ref_mem[40]);
    advance();
    chk_out("R13 counts from new start", 1'b1, ref_mem[41]);
    desel();
    idle();

    // R11: output enable.
    rd(6'd12, 0);
    #1 oe = 1'b0;
    #1 chk_out("R11 oe low releases", 1'b0, '0);
    oe = 1'b1;
    #1 chk_out("R11 oe restores data", 1'b1, ref_mem[12]);
    desel();
    idle();

    // R12: sleep.
    rd(6'd13, 0);
    #1 sleep = 1'b1;
    #1 chk_out("R12 sleep releases", 1'b0, '0);
    wr_word(6'd13, 32'hDEAD_DEAD);
    chk_out("R12 sleep still released", 1'b0, '0);
    #1 sleep = 1'b0;
    #1 chk_out("R12 state kept on wake", 1'b1, ref_mem[13]);
    rd(6'd13, 0);
    chk_out("R12 write ignored in sleep", 1'b1, ref_mem[13]);
    desel();
    idle();

    // R10: back-to-back deselects in pipelined mode.
    pipe_mode = 1'b1;
    rd(6'd14, 0);
    desel();
    chk_out("R10 pipelined hold", 1'b1, ref_mem[14]);
    desel();
    chk_out("R10 second deselect off", 1'b0, '0);
    idle();
    chk_out("R10 stays off", 1'b0, '0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule